// File: doc/BRIEF.md
# DMA Channel Status and Interrupt Flags

This block keeps the status word of a single DMA channel and raises that channel's interrupt request. It watches every source read and destination write that the channel makes. When an address lies above the programmed upper bound, or below the programmed lower bound while still above the peripheral-register region (which ends at 0x07FF), it sets the matching flag. The access itself is never held back: the check runs alongside it and the flag appears in the cycle after.

It also follows the remaining transfer count, which comes from outside the block. The block flags the halfway point and completion of a session. It flags an overrun when a trigger arrives while the channel is still busy with the previous one. It shows whether a word sits in the channel buffer waiting to be written. It holds a 6-bit trigger-select field, which a neighbouring trigger multiplexer decodes.

Software reads and writes the status word over a plain register strobe. The access strobes, count updates and trigger inputs are single-cycle status pulses with no back-pressure. The block accepts one event of each kind every cycle and never stalls its sources.

Top module: `dma_chan_status`

## Requirements
- R1: Status word layout: bit 15 buffer-pending (read-only), bits 13:8 trigger select, bit 7 upper-bound flag, bit 6 lower-bound flag, bit 5 done, bit 4 halfway, bit 3 overrun, bit 0 halfway-interrupt enable. Bits 14 and 2:1 always read 0. After reset the word reads 0x0000.
- R2: A source or destination access strobe whose address is strictly greater than `lim_hi` sets bit 7 in the following cycle. The access is not blocked.
- R3: An access whose address is strictly less than `lim_lo` and strictly greater than 0x07FF sets bit 6 in the following cycle.
- R4: On the rising edge of `chan_en` the block latches `cnt_val` as the start count. A later count update while enabled that carries floor(start/2) sets bit 4. For a start count of 1, this happens together with completion.
- R5: A count update to 0 while enabled sets bit 5. A rising edge of `chan_en` clears bit 5. If the channel is disabled before the count reaches 0, bit 5 stays 0.
- R6: `trig_in` while `busy` is high sets bit 3. `trig_in` while `busy` is low does not.
- R7: `buf_load` sets bit 15 and `buf_store` clears it. If both occur in the same cycle, load wins. Register writes do not change bit 15.
- R8: A register write loads bits 13:8, 7:3 and 0 from `reg_wdata`, and never causes an interrupt. If hardware sets a flag in the same cycle as a write, the flag ends up set.
- R9: `irq` is high for exactly the cycle after each hardware event: either bound flag, overrun, done, or halfway when bit 0 is 1. With bit 0 at 0, halfway raises no interrupt.
- R10: `trig_sel` always equals bits 13:8 of the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enabled |
| trig_in | input | 1 | Transfer trigger pulse |
| busy | input | 1 | Channel still servicing a trigger |
| src_stb | input | 1 | Source read performed |
| src_addr | input | ADDR_W | Source address |
| dst_stb | input | 1 | Destination write performed |
| dst_addr | input | ADDR_W | Destination address |
| lim_hi | input | ADDR_W | Upper address bound |
| lim_lo | input | ADDR_W | Lower address bound |
| cnt_upd | input | 1 | Remaining count updated |
| cnt_val | input | CNT_W | Remaining transfer count |
| buf_load | input | 1 | Word read into channel buffer |
| buf_store | input | 1 | Buffered word written out |
| reg_wr | input | 1 | Status word write strobe |
| reg_wdata | input | 16 | Status word write data |
| reg_rdata | output | 16 | Status word read data |
| trig_sel | output | 6 | Trigger select field |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench builds the block with ADDR_W=12 and CNT_W=6. The narrow address lets it drive all 4096 addresses through both access ports against two bound pairs, one of which has its lower bound inside the peripheral region, so the lower-bound flag must never fire for that pair. The 6-bit count lets it walk every start count from 1 to 63 down to zero with the halfway interrupt both on and off, which includes the odd starts, where floor(start/2) matters, and start 1, where halfway coincides with completion.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int REG_W    = 16;
  localparam int SEL_W    = 6;
  localparam int BIT_BUF  = 15;
  localparam int SEL_LSB  = 8;
  localparam int BIT_HI   = 7;
  localparam int BIT_LO   = 6;
  localparam int BIT_DONE = 5;
  localparam int BIT_HALF = 4;
  localparam int BIT_OVR  = 3;
  localparam int BIT_HEN  = 0;

  typedef struct packed {
    logic hi;
    logic lo;
    logic done;
    logic half;
    logic ovr;
  } hw_ev_t;
endpackage

// File: rtl/dma_lim_chk.sv
module dma_lim_chk #(
  parameter int ADDR_W     = 16,
  parameter int NPORT      = 2,
  parameter int PERIPH_TOP = 'h07FF
) (
  input  logic [NPORT-1:0]        stb,
  input  logic [NPORT*ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0]       lim_hi,
  input  logic [ADDR_W-1:0]       lim_lo,
  output logic                    hi_ev,
  output logic                    lo_ev
);
  localparam logic [ADDR_W-1:0] PTOP = ADDR_W'(PERIPH_TOP);

  logic [NPORT-1:0] hi_v;
  logic [NPORT-1:0] lo_v;

  // One comparator pair per access port.
  for (genvar i = 0; i < NPORT; i++) begin : g_port
    logic [ADDR_W-1:0] a;
    assign a       = addr[i*ADDR_W +: ADDR_W];
    assign hi_v[i] = stb[i] && (a > lim_hi);
    assign lo_v[i] = stb[i] && (a < lim_lo) && (a > PTOP);
  end

  assign hi_ev = |hi_v;
  assign lo_ev = |lo_v;
endmodule

// File: rtl/dma_cnt_track.sv
module dma_cnt_track #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_en,
  input  logic             cnt_upd,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             en_rise,
  output logic             half_ev,
  output logic             done_ev
);
  logic             en_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] half_thr;
  logic             live;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      start_q <= '0;
    end else begin
      en_q <= chan_en;
      if (en_rise) start_q <= cnt_val;
    end
  end

  assign en_rise  = chan_en && !en_q;
  assign half_thr = start_q >> 1;
  // Count updates count only once the session start has been latched.
  assign live     = chan_en && en_q && cnt_upd;
  assign half_ev  = live && (cnt_val == half_thr);
  assign done_ev  = live && (cnt_val == '0);
endmodule

// File: rtl/dma_flag_reg.sv
module dma_flag_reg
  import dma_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  hw_ev_t           ev,
  input  logic             en_rise,
  input  logic             buf_load,
  input  logic             buf_store,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [SEL_W-1:0] trig_sel,
  output logic             irq
);
  logic             buf_q, hi_q, lo_q, done_q, half_q, ovr_q, hen_q;
  logic             buf_n, hi_n, lo_n, done_n, half_n, ovr_n, hen_n;
  logic [SEL_W-1:0] sel_q, sel_n;
  logic             irq_n;

  always_comb begin
    buf_n  = buf_q;
    hi_n   = hi_q;
    lo_n   = lo_q;
    done_n = done_q;
    half_n = half_q;
    ovr_n  = ovr_q;
    hen_n  = hen_q;
    sel_n  = sel_q;
    if (reg_wr) begin
      hi_n   = reg_wdata[BIT_HI];
      lo_n   = reg_wdata[BIT_LO];
      done_n = reg_wdata[BIT_DONE];
      half_n = reg_wdata[BIT_HALF];
      ovr_n  = reg_wdata[BIT_OVR];
      hen_n  = reg_wdata[BIT_HEN];
      sel_n  = reg_wdata[SEL_LSB +: SEL_W];
    end
    if (en_rise) done_n = 1'b0;
    // Hardware setting wins over a same-cycle software clear.
    if (ev.hi)   hi_n   = 1'b1;
    if (ev.lo)   lo_n   = 1'b1;
    if (ev.done) done_n = 1'b1;
    if (ev.half) half_n = 1'b1;
    if (ev.ovr)  ovr_n  = 1'b1;
    if (buf_store) buf_n = 1'b0;
    if (buf_load)  buf_n = 1'b1;
    irq_n = ev.hi || ev.lo || ev.ovr || ev.done || (ev.half && hen_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q  <= 1'b0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
      done_q <= 1'b0;
      half_q <= 1'b0;
      ovr_q  <= 1'b0;
      hen_q  <= 1'b0;
      sel_q  <= '0;
      irq    <= 1'b0;
    end else begin
      buf_q  <= buf_n;
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      done_q <= done_n;
      half_q <= half_n;
      ovr_q  <= ovr_n;
      hen_q  <= hen_n;
      sel_q  <= sel_n;
      irq    <= irq_n;
    end
  end

  always_comb begin
    reg_rdata                     = '0;
    reg_rdata[BIT_BUF]            = buf_q;
    reg_rdata[SEL_LSB +: SEL_W]   = sel_q;
    reg_rdata[BIT_HI]             = hi_q;
    reg_rdata[BIT_LO]             = lo_q;
    reg_rdata[BIT_DONE]           = done_q;
    reg_rdata[BIT_HALF]           = half_q;
    reg_rdata[BIT_OVR]            = ovr_q;
    reg_rdata[BIT_HEN]            = hen_q;
  end

  assign trig_sel = sel_q;
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_stat_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int PERIPH_TOP = 'h07FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              trig_in,
  input  logic              busy,
  input  logic              src_stb,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic              dst_stb,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] lim_hi,
  input  logic [ADDR_W-1:0] lim_lo,
  input  logic              cnt_upd,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              buf_load,
  input  logic              buf_store,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic [5:0]        trig_sel,
  output logic              irq
);
  localparam int NPORT = 2;

  hw_ev_t ev;
  logic   en_rise;

  dma_lim_chk #(
    .ADDR_W    (ADDR_W),
    .NPORT     (NPORT),
    .PERIPH_TOP(PERIPH_TOP)
  ) u_lim (
    .stb   ({dst_stb, src_stb}),
    .addr  ({dst_addr, src_addr}),
    .lim_hi(lim_hi),
    .lim_lo(lim_lo),
    .hi_ev (ev.hi),
    .lo_ev (ev.lo)
  );

  dma_cnt_track #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .chan_en(chan_en),
    .cnt_upd(cnt_upd),
    .cnt_val(cnt_val),
    .en_rise(en_rise),
    .half_ev(ev.half),
    .done_ev(ev.done)
  );

  assign ev.ovr = trig_in && busy;

  dma_flag_reg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .en_rise  (en_rise),
    .buf_load (buf_load),
    .buf_store(buf_store),
    .reg_wr   (reg_wr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .trig_sel (trig_sel),
    .irq      (irq)
  );
endmodule

// File: rtl/dma_chan_status_chk.sv
module dma_chan_status_chk #(
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 16,
  parameter int PERIPH_TOP = 'h07FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              trig_in,
  input logic              busy,
  input logic              src_stb,
  input logic [ADDR_W-1:0] src_addr,
  input logic              dst_stb,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [ADDR_W-1:0] lim_hi,
  input logic [ADDR_W-1:0] lim_lo,
  input logic              cnt_upd,
  input logic              buf_load,
  input logic              reg_wr,
  input logic [15:0]       reg_wdata,
  input logic [15:0]       reg_rdata,
  input logic [5:0]        trig_sel,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] PTOP = ADDR_W'(PERIPH_TOP);

  p_hi_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_stb && src_addr > lim_hi) |=> (reg_rdata[7] && irq));

  p_lo_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_stb && dst_addr < lim_lo && dst_addr > PTOP) |=> (reg_rdata[6] && irq));

  p_done_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_en) |=> !reg_rdata[5]);

  p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_in && busy) |=> (reg_rdata[3] && irq));

  p_buf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> reg_rdata[15]);

  p_sw_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_stb && !dst_stb && !trig_in && !cnt_upd) |=> !irq);

  p_sel_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (trig_sel == $past(reg_wdata[13:8])));
endmodule

bind dma_chan_status dma_chan_status_chk #(
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W),
  .PERIPH_TOP(PERIPH_TOP)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .chan_en  (chan_en),
  .trig_in  (trig_in),
  .busy     (busy),
  .src_stb  (src_stb),
  .src_addr (src_addr),
  .dst_stb  (dst_stb),
  .dst_addr (dst_addr),
  .lim_hi   (lim_hi),
  .lim_lo   (lim_lo),
  .cnt_upd  (cnt_upd),
  .buf_load (buf_load),
  .reg_wr   (reg_wr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .trig_sel (trig_sel),
  .irq      (irq)
);

// File: tb/sim_dma_chan_status.sv
`timescale 1ns/1ps
module sim_dma_chan_status;
  localparam int AW = 12;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chan_en = 1'b0, trig_in = 1'b0, busy = 1'b0;
  logic          src_stb = 1'b0, dst_stb = 1'b0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0, lim_hi = '0, lim_lo = '0;
  logic          cnt_upd = 1'b0;
  logic [CW-1:0] cnt_val = '0;
  logic          buf_load = 1'b0, buf_store = 1'b0;
  logic          reg_wr = 1'b0;
  logic [15:0]   reg_wdata = '0;
  logic [15:0]   reg_rdata;
  logic [5:0]    trig_sel;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dma_chan_status #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .trig_in(trig_in), .busy(busy),
    .src_stb(src_stb), .src_addr(src_addr), .dst_stb(dst_stb), .dst_addr(dst_addr),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .cnt_upd(cnt_upd), .cnt_val(cnt_val),
    .buf_load(buf_load), .buf_store(buf_store), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_sel(trig_sel), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Write the status word; returns at the negedge after the write took effect.
  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  localparam logic [15:0] BASE = 16'h1500;  // trigger select 0x15, flags clear

  task automatic sweep(input bit use_dst, input logic [AW-1:0] hi, input logic [AW-1:0] lo);
    lim_hi = hi;
    lim_lo = lo;
    for (int a = 0; a < (1 << AW); a++) begin
      logic eh, el;
      @(negedge clk);
      if (use_dst) begin dst_stb = 1'b1; dst_addr = AW'(a); end
      else begin src_stb = 1'b1; src_addr = AW'(a); end
      @(negedge clk);
      src_stb = 1'b0;
      dst_stb = 1'b0;
      eh = (a > int'(hi));
      el = (a < int'(lo)) && (a > 'h7FF);
      check("R2 upper-bound flag", 32'(reg_rdata[7]), 32'(eh));
      check("R3 lower-bound flag", 32'(reg_rdata[6]), 32'(el));
      check("R9 bound irq", 32'(irq), 32'(eh | el));
      reg_wr = 1'b1;
      reg_wdata = BASE;
      @(negedge clk);
      reg_wr = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset word", 32'(reg_rdata), 32'h0);
    check("R9 reset irq", 32'(irq), 32'h0);

    // R1 / R8 / R10: write all ones, reserved and read-only bits stay 0.
    wr(16'hFFFF);
    check("R1 readback all ones", 32'(reg_rdata), 32'h3FF9);
    check("R8 software set no irq", 32'(irq), 32'h0);
    check("R10 trig_sel", 32'(trig_sel), 32'h3F);
    wr(BASE);
    check("R8 software clear", 32'(reg_rdata), 32'(BASE));
    check("R10 trig_sel after write", 32'(trig_sel), 32'h15);

    // R8: hardware set beats a same-cycle software clear.
    lim_hi = 12'h400;
    @(negedge clk);
    src_stb = 1'b1; src_addr = 12'h500; reg_wr = 1'b1; reg_wdata = BASE;
    @(negedge clk);
    src_stb = 1'b0; reg_wr = 1'b0;
    check("R8 hw wins over sw clear", 32'(reg_rdata[7]), 32'h1);
    wr(BASE);

    // R2 / R3 / R9 address sweeps.
    sweep(1'b0, 12'hC00, 12'h900);
    sweep(1'b1, 12'h7FF, 12'h300);

    // R6 overrun.
    @(negedge clk); trig_in = 1'b1; busy = 1'b0;
    @(negedge clk); trig_in = 1'b0;
    check("R6 idle trigger no overrun", 32'(reg_rdata[3]), 32'h0);
    check("R6 idle trigger no irq", 32'(irq), 32'h0);
    busy = 1'b1; trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0; busy = 1'b0;
    check("R6 busy trigger overrun", 32'(reg_rdata[3]), 32'h1);
    check("R9 overrun irq", 32'(irq), 32'h1);
    wr(BASE);

    // R7 buffer pending.
    @(negedge clk); buf_load = 1'b1;
    @(negedge clk); buf_load = 1'b0;
    check("R7 load sets pending", 32'(reg_rdata[15]), 32'h1);
    wr(16'h1500);
    check("R7 write keeps pending", 32'(reg_rdata[15]), 32'h1);
    @(negedge clk); buf_store = 1'b1;
    @(negedge clk); buf_store = 1'b0;
    check("R7 store clears pending", 32'(reg_rdata[15]), 32'h0);
    wr(16'h9500);
    check("R7 write cannot set pending", 32'(reg_rdata[15]), 32'h0);
    @(negedge clk); buf_load = 1'b1; buf_store = 1'b1;
    @(negedge clk); buf_load = 1'b0; buf_store = 1'b0;
    check("R7 load wins over store", 32'(reg_rdata[15]), 32'h1);
    @(negedge clk); buf_store = 1'b1;
    @(negedge clk); buf_store = 1'b0;

    // R4 / R5 / R9 count sweep, halfway interrupt off then on.
    for (int h = 0; h < 2; h++) begin
      for (int s = 1; s < (1 << CW); s++) begin
        wr(BASE | 16'(h));
        cnt_val = CW'(s);
        chan_en = 1'b1;
        @(negedge clk);
        check("R5 done clear at start", 32'(reg_rdata[5]), 32'h0);
        for (int c = s - 1; c >= 0; c--) begin
          cnt_val = CW'(c);
          cnt_upd = 1'b1;
          @(negedge clk);
          cnt_upd = 1'b0;
          check("R4 halfway flag", 32'(reg_rdata[4]), 32'(c <= s / 2));
          check("R5 done flag", 32'(reg_rdata[5]), 32'(c == 0));
          check("R9 count irq", 32'(irq), 32'((c == 0) || (h == 1 && c == s / 2)));
        end
        chan_en = 1'b0;
      end
    end

    // R5: done stays set while disabled, clears on re-enable, stays 0 on abort.
    @(negedge clk);
    check("R5 done held while disabled", 32'(reg_rdata[5]), 32'h1);
    cnt_val = 6'd20; chan_en = 1'b1;
    @(negedge clk);
    check("R5 done cleared on enable", 32'(reg_rdata[5]), 32'h0);
    cnt_val = 6'd19; cnt_upd = 1'b1;
    @(negedge clk);
    cnt_val = 6'd18;
    @(negedge clk);
    cnt_upd = 1'b0; chan_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R5 aborted session done low", 32'(reg_rdata[5]), 32'h0);
    check("R9 no irq on abort", 32'(irq), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule